// File: doc/BRIEF.md
# Masked GPIO Port with Edge Interrupts

A general purpose I/O port of `WIDTH` pins (32 by default) with a small word-addressed register interface. Software sets each pin's direction and output level. It reads the synchronized pin levels back. A mask register removes any group of pins from port operations: masked pins keep their output level when software writes the data, set or clear register, and they read back as zero. Dedicated set and clear registers change any group of output bits in one access without a read-modify-write. Every register write honours per-byte strobes, so byte, half-word and full-word accesses all work.

Every pin input passes through a two-flop synchronizer. Each pin compares its synchronized level with the previous sample to find edges. Each pin has a rising-edge enable and a falling-edge enable; setting both gives dual-edge detection. An enabled edge sets a sticky status bit. The interrupt output is the OR of all status bits. The wake output stays high while any status bit whose pin still has an enabled edge is set. Software clears status bits by writing ones to the status register.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset the direction, output, mask, rising-enable, falling-enable and status registers are all zero, so every pin is an input and `pad_oe_o`, `pad_out_o`, `irq_o` and `wake_o` are low.
- R2: A direction bit of 1 makes the pin an output: `pad_oe_o` equals the direction register (word 0) in the cycle after the write edge.
- R3: Every register write applies `be_i[k]` to bits 8k+7..8k only; bits of unstrobed bytes keep their value. Output register is word 1, mask word 3, rising enable word 6, falling enable word 7.
- R4: Bits set in the mask register keep their output value on writes to the output (word 1), set (word 4) and clear (word 5) registers.
- R5: Writing 1 to a bit of the set register drives that output bit high, and writing 1 to a bit of the clear register drives it low. Bits written 0 are unchanged. Both registers read as zero.
- R6: The pin register (word 2) returns the synchronized pin level whatever the direction, and returns 0 in masked positions. Reads of the output register also return 0 in masked positions.
- R7: A rising edge sets a pin's status bit only if its rising enable is set, and a falling edge only if its falling enable is set. Both enables give dual-edge detection. A pin level change reaches the status register on the third clock edge after it is applied.
- R8: Status bits (word 8) are sticky and clear only when 1 is written to them. When an enabled edge and a clear of the same bit land in the same cycle, the bit stays set.
- R9: `irq_o` is high exactly when any status bit is set.
- R10: `wake_o` is high while any status bit is set whose pin has its rising or falling enable set. Clearing the enables drops `wake_o` but leaves the status and `irq_o` unchanged.
- R11: A read request returns data on `rdata_o` with `rvalid_o` high one cycle later. Reads of unmapped words return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Register word index |
| be_i | input | WIDTH/8 | Per-byte write strobes |
| wdata_i | input | WIDTH | Write data |
| rdata_o | output | WIDTH | Read data |
| rvalid_o | output | 1 | Read data valid, one cycle after the request |
| pin_i | input | WIDTH | Pin input levels (asynchronous) |
| pad_out_o | output | WIDTH | Output levels to the pads |
| pad_oe_o | output | WIDTH | Output enables to the pads (1 = drive) |
| irq_o | output | 1 | Combined edge interrupt |
| wake_o | output | 1 | Wake request |

## Verification
Register writes are sampled on one clock edge and show on `pad_out_o` and `pad_oe_o` straight after it. The bench drives on the falling edge and checks these outputs at the next falling edge. Read data comes one edge after the request, so the driver queues the expected word when it issues the read, and the monitor pops it at the falling edge where `rvalid_o` is high. A pin change reaches the status register on the third rising edge, so the bench waits four cycles before it reads status or checks `irq_o` and `wake_o`. In the collision test the bench places the status clear exactly on that third edge, so the set-wins rule is what decides the result.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int unsigned REG_AW = 4;

  typedef enum logic [REG_AW-1:0] {
    A_DIR  = 4'd0,
    A_OUT  = 4'd1,
    A_PIN  = 4'd2,
    A_MASK = 4'd3,
    A_SET  = 4'd4,
    A_CLR  = 4'd5,
    A_RISE = 4'd6,
    A_FALL = 4'd7,
    A_STAT = 4'd8
  } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] ren_i,
  input  logic [W-1:0] fen_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] prev_q, stat_q;
  logic [W-1:0] rise, fall, ev;

  assign rise = lvl_i & ~prev_q;
  assign fall = ~lvl_i & prev_q;
  assign ev   = (rise & ren_i) | (fall & fen_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      stat_q <= '0;
    end else begin
      prev_q <= lvl_i;
      stat_q <= (stat_q & ~clr_i) | ev;  // set beats clear
    end
  end

  assign stat_o = stat_q;

  p_stat_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat_q & $past(stat_q & ~clr_i)) == $past(stat_q & ~clr_i)));

  p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev != '0) |=> ((stat_q & $past(ev)) == $past(ev)));

  p_only_enabled_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat_q & ~$past(stat_q) & ~$past(ren_i | fen_i)) == '0));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_edge_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned AW = REG_AW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [W/8-1:0]  be_i,
  input  logic [W-1:0]    wdata_i,
  output logic [W-1:0]    rdata_o,
  output logic            rvalid_o,
  input  logic [W-1:0]    lvl_i,
  input  logic [W-1:0]    stat_i,
  output logic [W-1:0]    dir_o,
  output logic [W-1:0]    out_o,
  output logic [W-1:0]    ren_o,
  output logic [W-1:0]    fen_o,
  output logic [W-1:0]    clr_o
);
  localparam int unsigned NB = W / 8;

  logic [W-1:0] bmask, wen_out, rd_mux;
  logic [W-1:0] dir_q, out_q, mask_q, ren_q, fen_q;
  logic         wr, rd;

  for (genvar k = 0; k < NB; k++) begin : g_bmask
    assign bmask[8*k +: 8] = {8{be_i[k]}};
  end

  assign wr      = req_i & we_i;
  assign rd      = req_i & ~we_i;
  assign wen_out = bmask & ~mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '0;
      out_q  <= '0;
      mask_q <= '0;
      ren_q  <= '0;
      fen_q  <= '0;
    end else if (wr) begin
      case (addr_i)
        A_DIR:   dir_q  <= (dir_q & ~bmask) | (wdata_i & bmask);
        A_OUT:   out_q  <= (out_q & ~wen_out) | (wdata_i & wen_out);
        A_MASK:  mask_q <= (mask_q & ~bmask) | (wdata_i & bmask);
        A_SET:   out_q  <= out_q | (wdata_i & wen_out);
        A_CLR:   out_q  <= out_q & ~(wdata_i & wen_out);
        A_RISE:  ren_q  <= (ren_q & ~bmask) | (wdata_i & bmask);
        A_FALL:  fen_q  <= (fen_q & ~bmask) | (wdata_i & bmask);
        default: ;
      endcase
    end
  end

  assign clr_o = (wr && addr_i == A_STAT) ? (wdata_i & bmask) : '0;

  always_comb begin
    case (addr_i)
      A_DIR:   rd_mux = dir_q;
      A_OUT:   rd_mux = out_q & ~mask_q;
      A_PIN:   rd_mux = lvl_i & ~mask_q;
      A_MASK:  rd_mux = mask_q;
      A_RISE:  rd_mux = ren_q;
      A_FALL:  rd_mux = fen_q;
      A_STAT:  rd_mux = stat_i;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd;
      rdata_o  <= rd ? rd_mux : '0;
    end
  end

  assign dir_o = dir_q;
  assign out_o = out_q;
  assign ren_o = ren_q;
  assign fen_o = fen_q;

  p_mask_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && (addr_i == A_OUT || addr_i == A_SET || addr_i == A_CLR))
      |=> (((out_q ^ $past(out_q)) & $past(mask_q)) == '0));

  p_set_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == A_SET) |=> ((~out_q & $past(wdata_i & wen_out)) == '0));

  p_clr_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == A_CLR) |=> ((out_q & $past(wdata_i & wen_out)) == '0));

  p_pin_hidden_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && addr_i == A_PIN) |=> ((rdata_o & $past(mask_q)) == '0));

  p_rvalid_lat_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd |=> rvalid_o);
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
  import gpio_edge_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned AW    = REG_AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [WIDTH/8-1:0] be_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  rdata_o,
  output logic              rvalid_o,
  input  logic [WIDTH-1:0]  pin_i,
  output logic [WIDTH-1:0]  pad_out_o,
  output logic [WIDTH-1:0]  pad_oe_o,
  output logic              irq_o,
  output logic              wake_o
);
  logic [WIDTH-1:0] lvl, stat, ren, fen, clr;

  gpio_sync #(.W(WIDTH)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (lvl)
  );

  gpio_regs #(.W(WIDTH), .AW(AW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .be_i    (be_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .rvalid_o(rvalid_o),
    .lvl_i   (lvl),
    .stat_i  (stat),
    .dir_o   (pad_oe_o),
    .out_o   (pad_out_o),
    .ren_o   (ren),
    .fen_o   (fen),
    .clr_o   (clr)
  );

  gpio_edge_det #(.W(WIDTH)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (lvl),
    .ren_i (ren),
    .fen_i (fen),
    .clr_i (clr),
    .stat_o(stat)
  );

  assign irq_o  = |stat;
  assign wake_o = |(stat & (ren | fen));

  p_wake_needs_irq_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> irq_o);
endmodule

// File: tb/gpio_edge_port_test.sv
module gpio_edge_port_test;
  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [3:0]    addr = '0;
  logic [3:0]    be = '0;
  logic [W-1:0]  wdata = '0, pins = '0;
  logic [W-1:0]  rdata, pad_out, pad_oe;
  logic          rvalid, irq, wake;

  int total = 0, bad = 0;
  bit done = 0;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];

  always #2 clk = ~clk;

  gpio_edge_port uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .be_i(be), .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid),
    .pin_i(pins), .pad_out_o(pad_out), .pad_oe_o(pad_oe),
    .irq_o(irq), .wake_o(wake)
  );

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [W-1:0] d, logic [3:0] b = 4'hF);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d; be = b;
    @(negedge clk);
    req = 0; we = 0; be = '0;
  endtask

  task automatic rd(logic [3:0] a, logic [W-1:0] exp, string tag);
    @(negedge clk);
    req = 1; we = 0; addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    req = 0;
  endtask

  task automatic set_pins(logic [W-1:0] v);
    @(negedge clk);
    pins = v;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R11 unexpected rvalid act=%h exp=none", rdata);
      end else begin
        chk(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pad_oe", pad_oe, '0);
    chk("R1 pad_out", pad_out, '0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 wake", {31'b0, wake}, 0);
    rd(4'd0, 32'h0, "R1 DIR");
    rd(4'd1, 32'h0, "R1 OUT");
    rd(4'd3, 32'h0, "R1 MASK");
    rd(4'd6, 32'h0, "R1 RISE");
    rd(4'd7, 32'h0, "R1 FALL");
    rd(4'd8, 32'h0, "R1 STAT");

    // R2 direction
    wr(4'd0, 32'h0000FFFF);
    chk("R2 pad_oe", pad_oe, 32'h0000FFFF);
    rd(4'd0, 32'h0000FFFF, "R2 DIR read");

    // R3 byte strobes
    wr(4'd1, 32'hA5A5A5A5, 4'b0101);
    chk("R3 out bytes 0,2", pad_out, 32'h00A500A5);
    wr(4'd1, 32'h12345678, 4'b1000);
    chk("R3 out byte 3", pad_out, 32'h12A500A5);
    wr(4'd6, 32'hFFFFFFFF, 4'b0010);
    rd(4'd6, 32'h0000FF00, "R3 RISE byte 1");
    wr(4'd6, 32'h0, 4'b0010);

    // R4 mask holds output bits
    wr(4'd3, 32'h0000FF00);
    wr(4'd1, 32'hFFFFFFFF);
    chk("R4 out write masked", pad_out, 32'hFFFF00FF);
    rd(4'd1, 32'hFFFF00FF, "R6 OUT read masked");
    wr(4'd5, 32'hFFFFFFFF);
    chk("R4 clr masked", pad_out, 32'h0);
    wr(4'd4, 32'h0000FF00);
    chk("R4 set masked", pad_out, 32'h0);
    wr(4'd3, 32'h0);

    // R5 set / clear
    wr(4'd4, 32'h80000001);
    chk("R5 set", pad_out, 32'h80000001);
    wr(4'd4, 32'h00000100);
    chk("R5 set keeps others", pad_out, 32'h80000101);
    wr(4'd5, 32'h80000000);
    chk("R5 clr", pad_out, 32'h00000101);
    rd(4'd4, 32'h0, "R5 SET reads 0");
    rd(4'd5, 32'h0, "R5 CLR reads 0");

    // R6 pin read, R7 disabled edges ignored
    set_pins(32'hDEADBEEF);
    repeat (4) @(negedge clk);
    rd(4'd2, 32'hDEADBEEF, "R6 PIN read");
    wr(4'd3, 32'hFFFF0000);
    rd(4'd2, 32'h0000BEEF, "R6 PIN masked");
    wr(4'd3, 32'h0);
    chk("R7 no irq when disabled", {31'b0, irq}, 0);
    rd(4'd8, 32'h0, "R7 STAT disabled");

    set_pins(32'h0);
    repeat (4) @(negedge clk);
    // R7 edges: bit0 rise, bit1 fall, bit2 both, bit3 none
    wr(4'd6, 32'h5);
    wr(4'd7, 32'h6);
    set_pins(32'hF);
    repeat (4) @(negedge clk);
    rd(4'd8, 32'h5, "R7 rising status");
    chk("R9 irq", {31'b0, irq}, 1);
    chk("R10 wake", {31'b0, wake}, 1);
    set_pins(32'h0);
    repeat (4) @(negedge clk);
    rd(4'd8, 32'h7, "R7 falling and dual");

    // R8 write-one-to-clear
    wr(4'd8, 32'h1);
    rd(4'd8, 32'h6, "R8 W1C");
    repeat (3) @(negedge clk);
    rd(4'd8, 32'h6, "R8 sticky");

    // R10 wake follows enables, irq does not
    wr(4'd6, 32'h0);
    wr(4'd7, 32'h0);
    chk("R10 wake off", {31'b0, wake}, 0);
    chk("R10 irq stays", {31'b0, irq}, 1);
    rd(4'd8, 32'h6, "R10 status kept");
    wr(4'd8, 32'hFFFFFFFF);
    chk("R9 irq cleared", {31'b0, irq}, 0);

    // R8 set wins over clear in the same cycle
    wr(4'd6, 32'h220);
    set_pins(32'h200);
    repeat (4) @(negedge clk);
    rd(4'd8, 32'h200, "R8 pre-collision");
    set_pins(32'h220);
    @(negedge clk);
    wr(4'd8, 32'h220);
    rd(4'd8, 32'h20, "R8 set wins");
    chk("R9 irq after collision", {31'b0, irq}, 1);

    // R11 unmapped word
    wr(4'd12, 32'hFFFFFFFF);
    rd(4'd12, 32'h0, "R11 unmapped read");
    rd(4'd0, 32'h0000FFFF, "R11 unmapped write ignored");
    chk("R11 out unchanged", pad_out, 32'h00000101);

    repeat (3) @(negedge clk);
    chk("R11 all reads returned", exp_q.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule